// File: doc/BRIEF.md
# Chainable Event Counter Bank

A bank of eight 32-bit counters that tallies activity in one cache slice. Each counter owns an 8-bit selector that picks what it counts: every clock, or one of six single-cycle strobes the slice raises for read hits and misses (all requesters and data-side only) and for write hits and misses. Software drives the bank through a plain valid/write/address/data port and reads it back through a combinational read-data path.

Any odd counter can be switched to count the carry-outs of the even counter directly below it, so a pair acts as one 64-bit counter. Each counter latches an overflow flag, either only when it wraps or, when selected, on every change of its bit 31 in either direction. An interrupt line gathers the flags that software has unmasked. Six address-filter words and eight per-counter control words are plain storage and do not qualify events.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset every mapped register reads 0 and `irq` is low.
- R2: The low 8 bits of the event-type word at 0x220+8n select counter n's event and read back with the upper bits zero: 0x01 counts every clock; 0x20..0x25 count `evt_strobe[0]`..`evt_strobe[5]` (read hit, read miss, data-side read hit, data-side read miss, write hit, write miss); every other code, 0 included, counts nothing. The counter value is read at 0x420+8n and wraps from all ones to 0.
- R3: Bit 0 of the global word at 0x500 enables the bank; no counter advances while it is clear. Counter n's enable is set by writing 1 to bit n at 0x508 and cleared by writing 1 to bit n at 0x50C; bits written as 0 leave the enable unchanged, and both addresses read the enable mask.
- R4: Interrupt enables follow the same rule through 0x510 (set) and 0x514 (clear); both addresses read the mask.
- R5: Bit n of the chain word at 0x718 exists only for odd n (even bits read 0 and have no effect). When set, odd counter n advances once for each wrap of counter n-1 and ignores its own selector.
- R6: Bit n of the status word at 0x740 is set when counter n wraps; writing 1 to a bit clears it, writing 0 leaves it. A set in the same cycle as a clear wins.
- R7: When bit n of the interrupt-control word at 0x96C is set, counter n's status bit is set on every change of its bit 31 caused by counting, rising or falling; when clear, a rise of bit 31 without a wrap sets nothing.
- R8: `irq` is high exactly while some counter has both its status bit and its interrupt enable set; it falls the cycle after those status bits are cleared.
- R9: Writing 1 to bit 1 of 0x500 clears in one cycle every counter value, counter enable, interrupt enable, status, chain and interrupt-control bit; bit 0 of the same write is still stored, and bit 1 always reads 0. Selectors, control words and filters keep their values.
- R10: A write to a counter's value word loads the written value even when that counter's event fires in the same cycle.
- R11: The six filter words at 0x300, 0x304, 0x308, 0x30C, 0x310, 0x314 and the control words at 0x120+8n are 32-bit read/write storage, reset to 0, with no effect on counting.
- R12: Any other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_strobe | input | 6 | Single-cycle cache event strobes |
| irq | output | 1 | Level interrupt |

## Verification
Counters start from values placed just below a wrap or just below the bit-31 rise, so one run with the bank enabled tells apart plain wrap flags, toggle-mode flags, a chained pair taking its even neighbour's carry, and selectors that must count nothing. A second short run from just below all ones shows a falling bit 31 flagged in toggle mode while a counter in wrap mode crossing the midpoint stays quiet. Value writes during counting, set/clear races on the mask words, and a long phase of random register writes with random strobes are compared every clock against a behavioural model, which separates set/clear priority errors and decode slips.

// File: rtl/evt_counter_bank.sv
module evt_counter_bank #(
  parameter int NCNT = 8,
  parameter int DW   = 32,
  parameter int AW   = 12,
  parameter int SELW = 8,
  parameter int NEVT = 6,
  parameter int NFLT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NEVT-1:0] evt_strobe,
  output logic          irq
);

  localparam int VAL_BASE = 'h420;
  localparam int CTL_BASE = 'h120;
  localparam int SEL_BASE = 'h220;
  localparam int FLT_BASE = 'h300;
  localparam int STRIDE   = 8;
  localparam logic [AW-1:0] A_GCTL = AW'('h500);
  localparam logic [AW-1:0] A_ENS  = AW'('h508);
  localparam logic [AW-1:0] A_ENC  = AW'('h50C);
  localparam logic [AW-1:0] A_IES  = AW'('h510);
  localparam logic [AW-1:0] A_IEC  = AW'('h514);
  localparam logic [AW-1:0] A_CHN  = AW'('h718);
  localparam logic [AW-1:0] A_OVF  = AW'('h740);
  localparam logic [AW-1:0] A_MSB  = AW'('h96C);
  localparam logic [SELW-1:0] EV_CYC  = SELW'(1);
  localparam int              EV_BASE = 'h20;
  localparam logic [NCNT-1:0] ODD_MASK = {(NCNT/2){2'b10}};

  logic [NCNT-1:0][DW-1:0]   cnt_q, ctl_q;
  logic [NCNT-1:0][SELW-1:0] sel_q;
  logic [NFLT-1:0][DW-1:0]   flt_q;
  logic [NCNT-1:0] cen_q, ien_q, ovf_q, chn_q, msb_q;
  logic            ben_q;
  logic [NCNT-1:0] hit, vwr, flag;

  wire wr   = bus_valid & bus_write;
  wire grst = wr && bus_addr == A_GCTL && bus_wdata[1];

  function automatic logic pick(input logic [SELW-1:0] sel, input logic [NEVT-1:0] s);
    logic r;
    r = (sel == EV_CYC);
    for (int e = 0; e < NEVT; e++)
      if (sel == SELW'(EV_BASE + e)) r = s[e];
    return r;
  endfunction

  function automatic logic [NCNT-1:0] wmask(input logic [AW-1:0] a);
    return (wr && bus_addr == a) ? bus_wdata[NCNT-1:0] : '0;
  endfunction

  for (genvar n = 0; n < NCNT; n++) begin : g_c
    logic          src, inc;
    logic [DW-1:0] nxt;

    assign hit[n] = pick(sel_q[n], evt_strobe);
    assign vwr[n] = wr && bus_addr == AW'(VAL_BASE + STRIDE*n);

    if (n % 2 == 1) begin : g_odd
      wire low_wrap = ben_q & cen_q[n-1] & hit[n-1] & ~vwr[n-1] & (&cnt_q[n-1]);
      assign src = chn_q[n] ? low_wrap : hit[n];
    end else begin : g_even
      assign src = hit[n];
    end

    assign inc     = ben_q & cen_q[n] & src & ~vwr[n];
    assign nxt     = cnt_q[n] + DW'(1);
    assign flag[n] = inc & (msb_q[n] ? (nxt[DW-1] ^ cnt_q[n][DW-1]) : (&cnt_q[n]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[n] <= '0;
        ctl_q[n] <= '0;
        sel_q[n] <= '0;
      end else begin
        if (grst)        cnt_q[n] <= '0;
        else if (vwr[n]) cnt_q[n] <= bus_wdata;
        else if (inc)    cnt_q[n] <= nxt;
        if (wr && bus_addr == AW'(CTL_BASE + STRIDE*n)) ctl_q[n] <= bus_wdata;
        if (wr && bus_addr == AW'(SEL_BASE + STRIDE*n)) sel_q[n] <= bus_wdata[SELW-1:0];
      end
    end
  end

  for (genvar f = 0; f < NFLT; f++) begin : g_f
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flt_q[f] <= '0;
      else if (wr && bus_addr == AW'(FLT_BASE + 4*f)) flt_q[f] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ben_q <= 1'b0;
      cen_q <= '0;
      ien_q <= '0;
      ovf_q <= '0;
      chn_q <= '0;
      msb_q <= '0;
    end else begin
      if (wr && bus_addr == A_GCTL) ben_q <= bus_wdata[0];
      if (grst) begin
        cen_q <= '0;
        ien_q <= '0;
        ovf_q <= '0;
        chn_q <= '0;
        msb_q <= '0;
      end else begin
        cen_q <= (cen_q | wmask(A_ENS)) & ~wmask(A_ENC);
        ien_q <= (ien_q | wmask(A_IES)) & ~wmask(A_IEC);
        ovf_q <= (ovf_q & ~wmask(A_OVF)) | flag;
        if (wr && bus_addr == A_CHN) chn_q <= bus_wdata[NCNT-1:0] & ODD_MASK;
        if (wr && bus_addr == A_MSB) msb_q <= bus_wdata[NCNT-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < NCNT; n++) begin
      if (bus_addr == AW'(VAL_BASE + STRIDE*n)) bus_rdata = cnt_q[n];
      if (bus_addr == AW'(CTL_BASE + STRIDE*n)) bus_rdata = ctl_q[n];
      if (bus_addr == AW'(SEL_BASE + STRIDE*n)) bus_rdata = DW'(sel_q[n]);
    end
    for (int f = 0; f < NFLT; f++)
      if (bus_addr == AW'(FLT_BASE + 4*f)) bus_rdata = flt_q[f];
    case (bus_addr)
      A_GCTL:        bus_rdata = DW'(ben_q);
      A_ENS, A_ENC:  bus_rdata = DW'(cen_q);
      A_IES, A_IEC:  bus_rdata = DW'(ien_q);
      A_CHN:         bus_rdata = DW'(chn_q);
      A_OVF:         bus_rdata = DW'(ovf_q);
      A_MSB:         bus_rdata = DW'(msb_q);
      default: ;
    endcase
  end

  assign irq = |(ovf_q & ien_q);

endmodule

module evt_counter_bank_chk #(
  parameter int NCNT = 8,
  parameter int DW   = 32,
  parameter int AW   = 12
) (
  input logic clk,
  input logic rst_n,
  input logic bus_valid,
  input logic bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic irq,
  input logic [NCNT-1:0] ovf_q,
  input logic [NCNT-1:0] cen_q,
  input logic [NCNT-1:0] ien_q,
  input logic ben_q,
  input logic [NCNT-1:0][DW-1:0] cnt_q
);
  wire wr = bus_valid & bus_write;

  // R9
  global_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == AW'('h500) && bus_wdata[1]) |=>
      (cnt_q == '0 && ovf_q == '0 && cen_q == '0 && ien_q == '0));

  // R6
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (bus_addr == AW'('h740) || (bus_addr == AW'('h500) && bus_wdata[1]))) |=>
      ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  // R3
  bank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ben_q && !wr) |=> $stable(cnt_q));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_q & ien_q) == '0) |-> !irq);

  // R10
  value_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == AW'('h420)) |=> (cnt_q[0] == $past(bus_wdata)));
endmodule

bind evt_counter_bank evt_counter_bank_chk #(.NCNT(NCNT), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq), .ovf_q(ovf_q),
  .cen_q(cen_q), .ien_q(ien_q), .ben_q(ben_q), .cnt_q(cnt_q));

// File: tb/sim_evt_counter_bank.sv
`timescale 1ns/1ps
module sim_evt_counter_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  evt_strobe = '0;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_counter_bank u0 (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_strobe(evt_strobe), .irq(irq));

  // behavioural reference
  logic [31:0] m_cnt [8];
  logic [31:0] m_ctl [8];
  logic [7:0]  m_sel [8];
  logic [31:0] m_flt [6];
  logic [7:0]  m_en, m_ie, m_ov, m_ch, m_msb;
  logic        m_ben;

  task automatic model_clear_all();
    for (int n = 0; n < 8; n++) begin m_cnt[n] = 0; m_ctl[n] = 0; m_sel[n] = 0; end
    for (int f = 0; f < 6; f++) m_flt[f] = 0;
    m_en = 0; m_ie = 0; m_ov = 0; m_ch = 0; m_msb = 0; m_ben = 0;
  endtask

  task automatic model_tick();
    bit wr;
    bit car [8];
    logic [31:0] old, nv;
    logic [7:0] setov;
    bit fire;
    int a;
    wr = bus_valid && bus_write;
    a = int'(bus_addr);
    if (wr && a == 'h500 && bus_wdata[1]) begin
      for (int n = 0; n < 8; n++) m_cnt[n] = 0;
      m_en = 0; m_ie = 0; m_ov = 0; m_ch = 0; m_msb = 0;
      m_ben = bus_wdata[0];
      return;
    end
    setov = 0;
    for (int n = 0; n < 8; n++) begin
      old = m_cnt[n];
      car[n] = 0;
      if ((n % 2) == 1 && m_ch[n]) fire = car[n-1];
      else if (m_sel[n] == 8'h01) fire = 1;
      else if (m_sel[n] >= 8'h20 && m_sel[n] <= 8'h25) fire = evt_strobe[m_sel[n] - 8'h20];
      else fire = 0;
      if (wr && a == 'h420 + 8*n) m_cnt[n] = bus_wdata;
      else if (m_ben && m_en[n] && fire) begin
        nv = old + 1;
        car[n] = (old == 32'hFFFF_FFFF);
        if (m_msb[n] ? (nv[31] != old[31]) : car[n]) setov[n] = 1;
        m_cnt[n] = nv;
      end
    end
    m_ov = (m_ov & ~((wr && a == 'h740) ? bus_wdata[7:0] : 8'h00)) | setov;
    if (wr) begin
      for (int n = 0; n < 8; n++) begin
        if (a == 'h120 + 8*n) m_ctl[n] = bus_wdata;
        if (a == 'h220 + 8*n) m_sel[n] = bus_wdata[7:0];
      end
      for (int f = 0; f < 6; f++) if (a == 'h300 + 4*f) m_flt[f] = bus_wdata;
      case (a)
        'h500: m_ben = bus_wdata[0];
        'h508: m_en = m_en | bus_wdata[7:0];
        'h50C: m_en = m_en & ~bus_wdata[7:0];
        'h510: m_ie = m_ie | bus_wdata[7:0];
        'h514: m_ie = m_ie & ~bus_wdata[7:0];
        'h718: m_ch = bus_wdata[7:0] & 8'hAA;
        'h96C: m_msb = bus_wdata[7:0];
        default: ;
      endcase
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_clear_all();
    else model_tick();
  end

  function automatic logic [31:0] mread(input logic [11:0] ad);
    int a = int'(ad);
    logic [31:0] r = 0;
    for (int n = 0; n < 8; n++) begin
      if (a == 'h420 + 8*n) r = m_cnt[n];
      if (a == 'h120 + 8*n) r = m_ctl[n];
      if (a == 'h220 + 8*n) r = {24'h0, m_sel[n]};
    end
    for (int f = 0; f < 6; f++) if (a == 'h300 + 4*f) r = m_flt[f];
    case (a)
      'h500: r = {31'h0, m_ben};
      'h508, 'h50C: r = {24'h0, m_en};
      'h510, 'h514: r = {24'h0, m_ie};
      'h718: r = {24'h0, m_ch};
      'h740: r = {24'h0, m_ov};
      'h96C: r = {24'h0, m_msb};
      default: ;
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [11:0] ad);
    int a = int'(ad);
    if (a >= 'h420 && a < 'h460) return "R2";
    if (a >= 'h220 && a < 'h260) return "R2";
    if (a >= 'h120 && a < 'h160) return "R11";
    if (a >= 'h300 && a < 'h318) return "R11";
    case (a)
      'h500: return "R9";
      'h508, 'h50C: return "R3";
      'h510, 'h514: return "R4";
      'h718: return "R5";
      'h740: return "R6";
      'h96C: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic cmp_model();
    logic [31:0] e;
    e = mread(bus_addr);
    checks++;
    if (bus_rdata !== e) begin
      errors++;
      $display("FAIL %s model addr=%h actual=%h expected=%h", req_of(bus_addr), bus_addr, bus_rdata, e);
    end
    checks++;
    if (irq !== |(m_ov & m_ie)) begin
      errors++;
      $display("FAIL R8 model irq actual=%b expected=%b", irq, |(m_ov & m_ie));
    end
  endtask

  task automatic step(input bit v, input bit w, input logic [11:0] a, input logic [31:0] d,
                      input logic [5:0] s);
    @(negedge clk);
    cmp_model();
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; evt_strobe = s;
    @(posedge clk);
    #1;
    bus_valid = 0; bus_write = 0; evt_strobe = 0;
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    step(1, 1, a, d, 6'h0);
  endtask

  task automatic chk_now(input logic [31:0] exp, input string tag);
    @(negedge clk);
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, bus_addr, bus_rdata, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    step(0, 0, a, 32'h0, 6'h0);
    chk_now(exp, tag);
  endtask

  task automatic chk_irq(input bit exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  logic [11:0] amap [20];

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    amap = '{12'h420, 12'h428, 12'h430, 12'h438, 12'h220, 12'h228, 12'h230, 12'h238,
             12'h500, 12'h508, 12'h50C, 12'h510, 12'h514, 12'h718, 12'h740, 12'h96C,
             12'h300, 12'h12C, 12'h404, 12'h458};
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    rd(12'h420, 32'h0, "R1");
    rd(12'h740, 32'h0, "R1");
    rd(12'h508, 32'h0, "R1");
    rd(12'h314, 32'h0, "R1");
    chk_irq(0, "R1");

    // setup with bank disabled
    wr_reg(12'h220, 32'h01); wr_reg(12'h228, 32'h20); wr_reg(12'h230, 32'h01);
    wr_reg(12'h238, 32'h21); wr_reg(12'h240, 32'h00); wr_reg(12'h248, 32'hFFFF_FF77);
    wr_reg(12'h250, 32'h25); wr_reg(12'h258, 32'h01);
    rd(12'h248, 32'h77, "R2");
    wr_reg(12'h420, 32'hFFFF_FFF0);
    wr_reg(12'h430, 32'h7FFF_FFF8);
    wr_reg(12'h458, 32'hFFFF_FFF8);
    wr_reg(12'h96C, 32'h04);
    wr_reg(12'h718, 32'h03);
    rd(12'h718, 32'h02, "R5");
    wr_reg(12'h508, 32'hFF);
    for (int i = 0; i < 5; i++) step(0, 0, 12'h420, 0, 6'h3F);
    rd(12'h420, 32'hFFFF_FFF0, "R3");
    wr_reg(12'h50C, 32'h10);
    rd(12'h508, 32'hEF, "R3");
    rd(12'h50C, 32'hEF, "R3");
    wr_reg(12'h508, 32'h10);
    rd(12'h50C, 32'hFF, "R3");
    wr_reg(12'h510, 32'h85);
    wr_reg(12'h514, 32'h01);
    rd(12'h510, 32'h84, "R4");
    rd(12'h514, 32'h84, "R4");

    // counting run: 20 increments
    wr_reg(12'h500, 32'h1);
    for (int i = 0; i < 19; i++) step(0, 0, 12'h438, 0, 6'($urandom_range(0, 63)));
    wr_reg(12'h500, 32'h0);
    rd(12'h420, 32'h0000_0004, "R2");
    rd(12'h428, 32'h0000_0001, "R5");
    rd(12'h430, 32'h8000_000C, "R7");
    rd(12'h440, 32'h0, "R2");
    rd(12'h448, 32'h0, "R2");
    rd(12'h458, 32'h0000_000C, "R2");
    rd(12'h740, 32'h85, "R6");
    chk_irq(1, "R8");
    wr_reg(12'h740, 32'h04);
    chk_irq(1, "R8");
    wr_reg(12'h740, 32'h80);
    chk_irq(0, "R8");
    rd(12'h740, 32'h01, "R6");

    // falling bit 31 in toggle mode, rising bit 31 in wrap mode
    wr_reg(12'h740, 32'hFF);
    wr_reg(12'h430, 32'hFFFF_FFFE);
    wr_reg(12'h458, 32'h7FFF_FFFF);
    wr_reg(12'h500, 32'h1);
    step(0, 0, 12'h430, 0, 6'h0);
    step(0, 0, 12'h430, 0, 6'h0);
    wr_reg(12'h500, 32'h0);
    rd(12'h430, 32'h0000_0001, "R7");
    rd(12'h458, 32'h8000_0002, "R7");
    rd(12'h740, 32'h04, "R7");
    chk_irq(1, "R8");

    // R10: value write beats a firing event
    wr_reg(12'h500, 32'h1);
    wr_reg(12'h420, 32'h100);
    chk_now(32'h100, "R10");
    wr_reg(12'h500, 32'h0);

    // R11 storage, R12 unmapped
    wr_reg(12'h308, 32'hDEAD_BEEF);
    rd(12'h308, 32'hDEAD_BEEF, "R11");
    wr_reg(12'h128, 32'h5A5A);
    rd(12'h128, 32'h5A5A, "R11");
    wr_reg(12'h404, 32'h1234);
    rd(12'h404, 32'h0, "R12");
    wr_reg(12'h96E, 32'hFF);
    rd(12'h96C, 32'h04, "R12");

    // R9: global reset
    wr_reg(12'h500, 32'h3);
    rd(12'h500, 32'h1, "R9");
    rd(12'h420, 32'h0, "R9");
    rd(12'h508, 32'h0, "R9");
    rd(12'h740, 32'h0, "R9");
    rd(12'h96C, 32'h0, "R9");
    rd(12'h718, 32'h0, "R9");
    rd(12'h220, 32'h01, "R9");
    rd(12'h308, 32'hDEAD_BEEF, "R9");

    // random traffic against the model
    wr_reg(12'h508, 32'hFF);
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = amap[$urandom_range(0, 19)];
      d = $urandom;
      if (a == 12'h500) d = {30'h0, ($urandom_range(0, 15) == 0), 1'b1};
      if (a >= 12'h420 && a < 12'h460 && d[0]) d = 32'hFFFF_FFF0 | d[3:0];
      step($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, a, d, 6'($urandom_range(0, 63)));
    end
    step(0, 0, 12'h740, 0, 6'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule